// File: doc/BRIEF.md
# Power-Management Register Bridge

This block lets a host processor reach the registers of an external power-management device through a plain 32-bit register bus. Host writes that land in a device window are posted into a small write queue. The block then drains that queue towards the device one transaction at a time. A host read is started by writing a device offset to a command register. Software then polls a result register until its busy flag drops. The result word carries the 16-bit register value together with an echo of the commanded address, so software can confirm that the data belongs to the request it made.

The device side is a single request/acknowledge port. The block raises a request with the address, direction and write data, and holds all of them steady until the device pulses done. An addressing-mode parameter selects three things together: the size of the device space (4 KiB, 16 KiB or 128 KiB), the host offset of the write window (0x8000, 0x8000 or 0x20000), and which command bits are echoed. A read command waits until every earlier posted write has reached the device.

Top module: `pmic_bridge`

## Requirements
- R1: After reset the result word at host offset 0x2C reads 0, the queue status word at 0x30 reads 0x400 (empty set, full and overflow clear), and no device request is raised.
- R2: A host write to offset 0x28 whose data carries a device offset, made while no read is busy, sets bit 31 of the word at 0x2C from the next cycle on. When the queue is empty, the block raises a device read (request high, write-enable low) one cycle later, with the device address equal to the low device-address bits of the commanded offset.
- R3: At the clock edge where done is high during a device read, bit 31 of the result word clears. From then on, bits 15:0 hold the returned value and bits 30:16 hold the echo.
- R4: In mode 0 (4 KiB) and mode 1 (16 KiB) the echo is bits 14:0 of the commanded offset. In mode 2 (128 KiB) it is bits 16:2.
- R5: A host write with an address inside the window (base 0x8000 for modes 0 and 1, 0x20000 for mode 2, size equal to the device space) becomes a device write. Its device address is the address minus the base, and its data is bits 15:0 of the host data. Host writes just below or just above the window produce no device write.
- R6: The queue holds 8 entries. The word at 0x30 reports full in bit 11 and empty in bit 10.
- R7: A window write that arrives while the queue is full is dropped and never reaches the device. It sets bit 0 of the word at 0x30, and that bit stays set until reset.
- R8: A read command is not issued to the device until the queue is empty and any device write in flight has completed, so a read returns the data of earlier posted writes.
- R9: A read command written while bit 31 is still set is ignored. The pending read completes with the first command's address and data.
- R10: The device port carries one transaction at a time. Address, direction and write data stay stable while the request is waiting for done, and queued writes reach the device in the order the host posted them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hst_wr | input | 1 | Host write strobe, one cycle per write |
| hst_addr | input | HADDR_W (18) | Host byte address |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data for the current address, combinational |
| dev_req | output | 1 | Device transaction request, held until done |
| dev_we | output | 1 | 1 for a device write, 0 for a device read |
| dev_addr | output | DEV_AW (12 in mode 0) | Device register address |
| dev_wdata | output | 16 | Device write data |
| dev_rdata | input | 16 | Device read data, valid with done on a read |
| dev_done | input | 1 | Device completion strobe |

## Verification
A command write is captured at one edge. Its busy flag is visible right after that edge, and a device read is raised after the following edge. A window write shows as a non-empty queue after its own edge and as a device write request one edge later. A completion edge with done high clears busy and updates the result word on the same edge. The bench drives the host at the falling edge and samples just after a rising edge or after a falling edge. It polls busy rather than assuming a device latency, and it sets the device-model latency wherever a check depends on counting cycles, for example to overfill the eight-entry queue.

// File: rtl/pmic_bridge_pkg.sv
package pmic_bridge_pkg;

   localparam int CMD_W   = 17;
   localparam int VAL_W   = 16;
   localparam int ECHO_W  = 15;

   localparam int REG_RDCMD  = 'h28;
   localparam int REG_RDDATA = 'h2C;
   localparam int REG_QSTAT  = 'h30;

   localparam int QS_FULL_BIT  = 11;
   localparam int QS_EMPTY_BIT = 10;
   localparam int QS_OVF_BIT   = 0;
   localparam int RW_BUSY_BIT  = 31;

   typedef enum logic [1:0] {
      DP_IDLE  = 2'd0,
      DP_WRITE = 2'd1,
      DP_READ  = 2'd2
   } dp_state_e;

   function automatic int dev_aw_f(input int mode);
      return (mode == 0) ? 12 : ((mode == 1) ? 14 : 17);
   endfunction

   function automatic int win_base_f(input int mode);
      return (mode == 2) ? 'h20000 : 'h8000;
   endfunction

endpackage

// File: rtl/pbr_wqueue.sv
module pbr_wqueue #(
   parameter int DEPTH = 8,
   parameter int WIDTH = 28
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             full,
   output logic             empty,
   output logic             drop
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
   localparam logic [CNT_W-1:0] CMAX = CNT_W'(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("pbr_wqueue: DEPTH must be at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wp, rp, wp_nx, rp_nx;
   logic [CNT_W-1:0] cnt;
   logic             do_push, do_pop;

   assign full    = (cnt == CMAX);
   assign empty   = (cnt == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign drop    = push && full;
   assign dout    = mem[rp];

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wp_nx = wp + 1'b1;
      assign rp_nx = rp + 1'b1;
   end else begin : g_wrap
      assign wp_nx = (wp == LAST) ? '0 : wp + 1'b1;
      assign rp_nx = (rp == LAST) ? '0 : rp + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp_nx;
         if (do_pop)  rp <= rp_nx;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CMAX);

   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> full && (cnt == CMAX));

   p_pop_moves_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !empty && !push) |=> !full);

endmodule

// File: rtl/pbr_rdcmd.sv
module pbr_rdcmd
   import pmic_bridge_pkg::*;
#(
   parameter int DEV_AW     = 12,
   parameter bit ECHO_SHIFT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr,
   input  logic [CMD_W-1:0]  cmd_val,
   input  logic              rd_launch,
   input  logic              rd_done,
   input  logic [VAL_W-1:0]  rd_val,
   output logic              rd_pend,
   output logic [DEV_AW-1:0] rd_addr,
   output logic [31:0]       rd_word
);
   if (DEV_AW > CMD_W) begin : g_bad_aw
      $error("pbr_rdcmd: DEV_AW exceeds the command width");
   end

   logic              busy;
   logic [CMD_W-1:0]  cmd_q;
   logic [ECHO_W-1:0] echo_q, echo_w;
   logic [VAL_W-1:0]  val_q;
   logic              accept;

   assign accept = cmd_wr && !busy;

   if (ECHO_SHIFT) begin : g_echo_shift
      assign echo_w = cmd_q[ECHO_W+1:2];
   end else begin : g_echo_low
      assign echo_w = cmd_q[ECHO_W-1:0];
   end

   logic unused_cmd;
   assign unused_cmd = ^cmd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         rd_pend <= 1'b0;
         cmd_q   <= '0;
         echo_q  <= '0;
         val_q   <= '0;
      end else begin
         if (accept) begin
            busy    <= 1'b1;
            rd_pend <= 1'b1;
            cmd_q   <= cmd_val;
         end else begin
            if (rd_launch) rd_pend <= 1'b0;
            if (rd_done) begin
               busy   <= 1'b0;
               val_q  <= rd_val;
               echo_q <= echo_w;
            end
         end
      end
   end

   assign rd_addr = cmd_q[DEV_AW-1:0];
   assign rd_word = {busy, echo_q, val_q};

   p_busy_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && !rd_word[RW_BUSY_BIT]) |=> rd_word[RW_BUSY_BIT]);

   p_busy_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done |=> !rd_word[RW_BUSY_BIT]);

   p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && rd_word[RW_BUSY_BIT]) |=> $stable(rd_addr));

   p_pend_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_pend |-> rd_word[RW_BUSY_BIT]);

endmodule

// File: rtl/pbr_devport.sv
module pbr_devport
   import pmic_bridge_pkg::*;
#(
   parameter int DEV_AW = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wq_empty,
   input  logic [DEV_AW-1:0] wq_addr,
   input  logic [VAL_W-1:0]  wq_data,
   output logic              wq_pop,
   input  logic              rd_pend,
   input  logic [DEV_AW-1:0] rd_addr,
   output logic              rd_launch,
   output logic              rd_done,
   output logic              dev_req,
   output logic              dev_we,
   output logic [DEV_AW-1:0] dev_addr,
   output logic [VAL_W-1:0]  dev_wdata,
   input  logic              dev_done
);
   dp_state_e st;

   assign wq_pop    = (st == DP_IDLE) && !wq_empty;
   assign rd_launch = (st == DP_IDLE) && wq_empty && rd_pend;
   assign rd_done   = (st == DP_READ) && dev_done;
   assign dev_req   = (st != DP_IDLE);
   assign dev_we    = (st == DP_WRITE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= DP_IDLE;
         dev_addr  <= '0;
         dev_wdata <= '0;
      end else begin
         case (st)
            DP_IDLE: begin
               if (!wq_empty) begin
                  st        <= DP_WRITE;
                  dev_addr  <= wq_addr;
                  dev_wdata <= wq_data;
               end else if (rd_pend) begin
                  st       <= DP_READ;
                  dev_addr <= rd_addr;
               end
            end
            default: begin
               if (dev_done) st <= DP_IDLE;
            end
         endcase
      end
   end

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_req && !dev_done) |=> dev_req && $stable(dev_addr)
                                 && $stable(dev_we) && $stable(dev_wdata));

   p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_req && dev_done) |=> !dev_req);

endmodule

// File: rtl/pmic_bridge.sv
module pmic_bridge
   import pmic_bridge_pkg::*;
#(
   parameter int ADDR_MODE  = 0,
   parameter int FIFO_DEPTH = 8,
   parameter int HADDR_W    = 18,
   localparam int DEV_AW    = dev_aw_f(ADDR_MODE)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hst_wr,
   input  logic [HADDR_W-1:0] hst_addr,
   input  logic [31:0]        hst_wdata,
   output logic [31:0]        hst_rdata,
   output logic               dev_req,
   output logic               dev_we,
   output logic [DEV_AW-1:0]  dev_addr,
   output logic [VAL_W-1:0]   dev_wdata,
   input  logic [VAL_W-1:0]   dev_rdata,
   input  logic               dev_done
);
   localparam int WIN_BASE = win_base_f(ADDR_MODE);
   localparam int WIN_SIZE = 1 << DEV_AW;
   localparam int WIN_END  = WIN_BASE + WIN_SIZE;
   localparam int ENT_W    = DEV_AW + VAL_W;
   localparam bit ECHO_SH  = (ADDR_MODE == 2);
   localparam logic [HADDR_W:0]   WIN_LO = (HADDR_W + 1)'(WIN_BASE);
   localparam logic [HADDR_W:0]   WIN_HI = (HADDR_W + 1)'(WIN_END);
   localparam logic [HADDR_W-1:0] A_CMD  = HADDR_W'(REG_RDCMD);
   localparam logic [HADDR_W-1:0] A_DATA = HADDR_W'(REG_RDDATA);
   localparam logic [HADDR_W-1:0] A_STAT = HADDR_W'(REG_QSTAT);

   if (ADDR_MODE < 0 || ADDR_MODE > 2) begin : g_bad_mode
      $error("pmic_bridge: ADDR_MODE must be 0, 1 or 2");
   end
   if ((WIN_BASE % WIN_SIZE) != 0) begin : g_bad_align
      $error("pmic_bridge: window base must be aligned to its size");
   end
   if ((1 << HADDR_W) < WIN_END) begin : g_bad_haddr
      $error("pmic_bridge: HADDR_W too narrow for the write window");
   end

   logic [HADDR_W:0]  addr_x;
   logic              win_hit, cmd_wr;
   logic [ENT_W-1:0]  wq_din, wq_dout;
   logic              wq_pop, wq_full, wq_empty, wq_drop;
   logic              rd_pend, rd_launch, rd_done;
   logic [DEV_AW-1:0] rd_addr;
   logic [31:0]       rd_word, st_word;
   logic              ovf_q;

   assign addr_x  = {1'b0, hst_addr};
   assign win_hit = hst_wr && (addr_x >= WIN_LO) && (addr_x < WIN_HI);
   assign cmd_wr  = hst_wr && (hst_addr == A_CMD);
   assign wq_din  = {hst_addr[DEV_AW-1:0], hst_wdata[VAL_W-1:0]};

   logic unused_wd;
   assign unused_wd = ^hst_wdata[31:CMD_W];

   pbr_wqueue #(
      .DEPTH (FIFO_DEPTH),
      .WIDTH (ENT_W)
   ) u_wq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (win_hit),
      .din   (wq_din),
      .pop   (wq_pop),
      .dout  (wq_dout),
      .full  (wq_full),
      .empty (wq_empty),
      .drop  (wq_drop)
   );

   pbr_rdcmd #(
      .DEV_AW     (DEV_AW),
      .ECHO_SHIFT (ECHO_SH)
   ) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_wr    (cmd_wr),
      .cmd_val   (hst_wdata[CMD_W-1:0]),
      .rd_launch (rd_launch),
      .rd_done   (rd_done),
      .rd_val    (dev_rdata),
      .rd_pend   (rd_pend),
      .rd_addr   (rd_addr),
      .rd_word   (rd_word)
   );

   pbr_devport #(
      .DEV_AW (DEV_AW)
   ) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .wq_empty  (wq_empty),
      .wq_addr   (wq_dout[ENT_W-1:VAL_W]),
      .wq_data   (wq_dout[VAL_W-1:0]),
      .wq_pop    (wq_pop),
      .rd_pend   (rd_pend),
      .rd_addr   (rd_addr),
      .rd_launch (rd_launch),
      .rd_done   (rd_done),
      .dev_req   (dev_req),
      .dev_we    (dev_we),
      .dev_addr  (dev_addr),
      .dev_wdata (dev_wdata),
      .dev_done  (dev_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovf_q <= 1'b0;
      else if (wq_drop) ovf_q <= 1'b1;
   end

   always_comb begin
      st_word               = '0;
      st_word[QS_FULL_BIT]  = wq_full;
      st_word[QS_EMPTY_BIT] = wq_empty;
      st_word[QS_OVF_BIT]   = ovf_q;
   end

   always_comb begin
      case (hst_addr)
         A_DATA:  hst_rdata = rd_word;
         A_STAT:  hst_rdata = st_word;
         default: hst_rdata = '0;
      endcase
   end

   p_rd_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_req && !dev_we && !$past(dev_req)) |-> $past(wq_empty));

   p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |=> ovf_q);

   p_drop_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (win_hit && wq_full) |=> ovf_q);

   p_full_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(wq_full && wq_empty));

endmodule

// File: tb/pmic_bridge_tb_top.sv
`timescale 1ns/1ps

module pbr_devmodel #(
   parameter int AW = 17
) (
   input  logic          clk,
   input  logic          req,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [15:0]   wdata,
   input  int            lat,
   output logic [15:0]   rdata,
   output logic          done
);
   int          wcount;
   int          waitc;
   logic [AW-1:0] log_addr [64];
   logic [15:0]   log_data [64];
   logic [15:0]   mem [256];

   function automatic logic [15:0] seed_val(input int i);
      return 16'(i * 16'h0101) ^ 16'hC3A5;
   endfunction

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = seed_val(i);
      done   = 1'b0;
      rdata  = '0;
      wcount = 0;
      waitc  = 0;
      forever begin
         @(negedge clk);
         done = 1'b0;
         if (req) begin
            if (waitc < lat) waitc++;
            else begin
               waitc = 0;
               done  = 1'b1;
               if (we) begin
                  mem[addr[7:0]] = wdata;
                  if (wcount < 64) begin
                     log_addr[wcount] = addr;
                     log_data[wcount] = wdata;
                  end
                  wcount++;
               end else begin
                  rdata = mem[addr[7:0]];
               end
            end
         end
      end
   end
endmodule

module pmic_bridge_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hst_wr = 1'b0;
   logic [17:0] hst_addr = '0;
   logic [31:0] hst_wdata = '0;
   logic [31:0] rdata0, rdata1;
   logic        req0, we0, done0, req1, we1, done1;
   logic [11:0] addr0;
   logic [16:0] addr1, addr0x;
   logic [15:0] wd0, wd1, rd0, rd1;
   int          lat0 = 3, lat1 = 2;
   int          total = 0, bad = 0;
   bit          finished = 0;
   logic [15:0] exp0 [256];
   logic [15:0] exp1 [256];

   always #2 clk = ~clk;

   pmic_bridge #(.ADDR_MODE(0)) dut_i (
      .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_addr(hst_addr),
      .hst_wdata(hst_wdata), .hst_rdata(rdata0), .dev_req(req0), .dev_we(we0),
      .dev_addr(addr0), .dev_wdata(wd0), .dev_rdata(rd0), .dev_done(done0));

   pmic_bridge #(.ADDR_MODE(2)) dut_x (
      .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_addr(hst_addr),
      .hst_wdata(hst_wdata), .hst_rdata(rdata1), .dev_req(req1), .dev_we(we1),
      .dev_addr(addr1), .dev_wdata(wd1), .dev_rdata(rd1), .dev_done(done1));

   assign addr0x = {5'b0, addr0};

   pbr_devmodel #(.AW(17)) m0 (.clk(clk), .req(req0), .we(we0), .addr(addr0x),
      .wdata(wd0), .lat(lat0), .rdata(rd0), .done(done0));
   pbr_devmodel #(.AW(17)) m1 (.clk(clk), .req(req1), .we(we1), .addr(addr1),
      .wdata(wd1), .lat(lat1), .rdata(rd1), .done(done1));

   function automatic logic [15:0] seed_val(input int i);
      return 16'(i * 16'h0101) ^ 16'hC3A5;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic hw(input logic [17:0] a, input logic [31:0] d);
      @(negedge clk);
      hst_wr    = 1'b1;
      hst_addr  = a;
      hst_wdata = d;
      @(posedge clk);
      #1;
      hst_wr = 1'b0;
   endtask

   task automatic hr(input logic [17:0] a, output logic [31:0] r0, output logic [31:0] r1);
      hst_addr = a;
      #1;
      r0 = rdata0;
      r1 = rdata1;
   endtask

   task automatic wait_read(output logic [31:0] w0, output logic [31:0] w1);
      for (int n = 0; n < 400; n++) begin
         hr(18'h2C, w0, w1);
         if (!w0[31] && !w1[31]) return;
         @(negedge clk);
      end
   endtask

   task automatic drain();
      logic [31:0] s0, s1;
      for (int n = 0; n < 600; n++) begin
         @(negedge clk);
         hr(18'h30, s0, s1);
         if (s0[10] && s1[10] && !req0 && !req1) return;
      end
   endtask

   initial begin
      #(4 * 150000);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] w0, w1, s0, s1;
      logic [16:0] off;
      int          wc;
      for (int i = 0; i < 256; i++) begin
         exp0[i] = seed_val(i);
         exp1[i] = seed_val(i);
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      hr(18'h2C, w0, w1);
      check("R1 rdword m0", w0, 32'h0);
      check("R1 rdword m2", w1, 32'h0);
      hr(18'h30, s0, s1);
      check("R1 status m0", s0, 32'h400);
      check("R1 status m2", s1, 32'h400);
      check("R1 no request", {31'b0, req0 | req1}, 32'h0);

      // R2 R3 R4: read sweep with echo in both modes
      for (int k = 0; k < 24; k++) begin
         off = 17'(k * 32'h2B5C + 32'h37);
         hw(18'h28, {15'b0, off});
         if (k == 0) begin
            hr(18'h2C, w0, w1);
            check("R2 busy after command m0", {31'b0, w0[31]}, 32'h1);
            check("R2 busy after command m2", {31'b0, w1[31]}, 32'h1);
            @(posedge clk);
            #1;
            check("R2 read request", {req0, we0, addr0}, {2'b10, off[11:0]});
         end
         wait_read(w0, w1);
         check("R3 R4 result mode0", w0, {1'b0, off[14:0], exp0[off[7:0]]});
         check("R3 R4 result mode2", w1, {1'b0, off[16:2], exp1[off[7:0]]});
         @(negedge clk);
      end

      // R5: window write timing and data
      hw(18'h8044, 32'h0000_BEEF);
      exp0[8'h44] = 16'hBEEF;
      hr(18'h30, s0, s1);
      check("R5 queue not empty", s0, 32'h0);
      @(posedge clk);
      #1;
      check("R5 write request", {req0, we0, addr0, wd0}, {2'b11, 12'h044, 16'hBEEF});
      drain();
      hw(18'h28, 32'h44);
      wait_read(w0, w1);
      check("R5 readback m0", w0, {1'b0, 15'h44, 16'hBEEF});
      check("R5 other mode untouched", w1, {1'b0, 15'h11, exp1[8'h44]});
      check("R5 mode2 no writes", m1.wcount, 0);

      // R5: window edges, mode 0
      wc = m0.wcount;
      hw(18'h8FFE, 32'h1111);
      hw(18'h9000, 32'h2222);
      hw(18'h7FFE, 32'h3333);
      drain();
      exp0[8'hFE] = 16'h1111;
      check("R5 edge count m0", m0.wcount, wc + 1);
      check("R5 edge last m0", {m0.log_addr[wc], m0.log_data[wc]}, {17'hFFE, 16'h1111});

      // R5: window edges, mode 2
      hw(18'h20010, 32'h4444);
      hw(18'h3FFFE, 32'h5555);
      hw(18'h1FFFE, 32'h6666);
      drain();
      exp1[8'h10] = 16'h4444;
      exp1[8'hFE] = 16'h5555;
      check("R5 edge count m2", m1.wcount, 2);
      check("R5 edge first m2", {m1.log_addr[0], m1.log_data[0]}, {17'h10, 16'h4444});
      check("R5 edge last m2", {m1.log_addr[1], m1.log_data[1]}, {17'h1FFFE, 16'h5555});
      check("R5 edge m0 unchanged", m0.wcount, wc + 1);

      // R10: queued writes drain in order
      lat0 = 5;
      wc = m0.wcount;
      for (int j = 0; j < 4; j++) hw(18'(18'h8200 + 2 * j), 32'(32'hA0 + j));
      drain();
      for (int j = 0; j < 4; j++) begin
         exp0[2 * j] = 16'(16'hA0 + j);
         check("R10 write order", {m0.log_addr[wc + j], m0.log_data[wc + j]},
               {17'(17'h200 + 2 * j), 16'(16'hA0 + j)});
      end

      // R8: read right after a posted write to the same register
      hw(18'h8300, 32'h7E57);
      hw(18'h28, 32'h300);
      exp0[8'h00] = 16'h7E57;
      wait_read(w0, w1);
      check("R8 read sees posted write", w0, {1'b0, 15'h300, 16'h7E57});
      check("R8 mode2 read", w1, {1'b0, 15'hC0, exp1[8'h00]});

      // R9: second command while busy is ignored
      lat0 = 20;
      lat1 = 20;
      hw(18'h28, 32'h0004C);
      hw(18'h28, 32'h00090);
      wait_read(w0, w1);
      check("R9 first command kept m0", w0, {1'b0, 15'h4C, exp0[8'h4C]});
      check("R9 first command kept m2", w1, {1'b0, 15'h13, exp1[8'h4C]});
      lat1 = 2;
      @(negedge clk);

      // R6 R7: fill queue past depth 8
      lat0 = 16;
      wc = m0.wcount;
      for (int j = 0; j < 10; j++) hw(18'(18'h8100 + 4 * j), 32'(32'h1000 + j));
      hr(18'h30, s0, s1);
      check("R6 R7 full and overflow", s0, 32'h801);
      check("R7 mode2 no overflow", s1, 32'h400);
      drain();
      for (int j = 0; j < 9; j++) exp0[4 * j] = 16'(16'h1000 + j);
      hr(18'h30, s0, s1);
      check("R7 overflow sticky after drain", s0, 32'h401);
      check("R7 dropped write count", m0.wcount, wc + 9);
      lat0 = 3;
      hw(18'h28, 32'h124);
      wait_read(w0, w1);
      check("R7 dropped write absent", w0, {1'b0, 15'h124, exp0[8'h24]});
      hw(18'h28, 32'h120);
      wait_read(w0, w1);
      check("R6 ninth write present", w0, {1'b0, 15'h120, 16'h1008});
      hr(18'h30, s0, s1);
      check("R7 overflow still set", s0, 32'h401);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule